// File: doc/BRIEF.md
# Multi-Line Transmit Fetch Sequencer

This block is the transmit engine for a sixteen-line serial multiplexer. Every line owns an 18-bit memory pointer and a 16-bit byte count. The count is loaded as the two's-complement negative of the transfer length. Software reaches one line's pointer and count at a time, through a line-select field in the control/status word. Software starts a line by setting that line's bit in a shared activity mask.

While any line is active with a nonzero count, a round-robin arbiter picks the next line. The block reads one byte for that line through a request/acknowledge memory port and offers the byte on a ready/valid sink interface, tagged with the line number. Each byte fetched moves the pointer and the count up by one. When a count reaches zero, the hardware removes the line from the activity mask and raises a transmit-done flag, which can drive an interrupt.

A read that gets no acknowledge within a bounded time sets a memory-error flag and retires the line. Software can stop a running line early by rewriting its count to all ones. The pointer then records how far the transfer got.

Top module: `txdma_seq`

## Requirements
- R1: After reset the control/status word (offset 0), the activity mask (offset 3) and `irq` read zero, and `mem_req` is low.
- R2: Bits 3:0 of the control/status word choose the line whose address (offset 1) and count (offset 2) host accesses reach; accesses to one line leave every other line's registers unchanged.
- R3: A control/status write stores bits 5:4 as address bits 17:16 of the line named in bits 3:0 of the same write; reads return them in bits 5:4 for the selected line, and `mem_addr` is {bits 17:16, offset-1 value}.
- R4: Each acknowledged byte adds one to the line's 18-bit address, carrying from bit 15 into bit 16, and adds one to its count.
- R5: A line whose activity bit is set and whose count is nonzero has bytes delivered on `tx_data` with `tx_line` naming it, in ascending address order; `tx_valid`, `tx_data` and `tx_line` stay steady until `tx_ready[tx_line]` is high.
- R6: When an active line's count is zero and no fetch for it is in progress, its activity bit clears and bit 15 (transmit done) sets; `irq` is bit 15 AND bit 13 (interrupt enable); a control/status write with bit 15 at 0 clears bit 15.
- R7: Active lines are served one byte at a time in round-robin order, so two busy lines alternate byte by byte.
- R8: Writing 16'hFFFF to an active line's count stops it after at most one more byte; afterward its address equals start address plus bytes delivered.
- R9: A request that receives no `mem_ack` within TMO (32) cycles is withdrawn, sets bit 10 (memory error), and clears the line's activity bit without setting bit 15; a control/status write with bit 8 at 1 clears bit 10.
- R10: A host write to the activity mask in the same cycle that the hardware clears a completing line leaves that line's bit clear; the other bits take the written values.
- R11: Setting an activity bit for a line whose count is already zero starts no fetch; the bit clears and bit 15 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register offset: 0 control/status, 1 address, 2 count, 3 activity mask |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| irq | output | 1 | Transmit-done interrupt request |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 18 | Memory byte address |
| mem_ack | input | 1 | Read acknowledge, `mem_rdata` valid |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Byte offered to a line sink |
| tx_line | output | 4 | Line the byte belongs to |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 16 | Per-line sink ready |

## Verification
The hardest case to reach is a host rewrite of the activity mask that lands in exactly the cycle in which the hardware retires a line. That cycle depends on memory latency, on sink readiness and on the arbiter's state. The stimulus sweeps the delay between starting a one-byte line and a read-modify-write of the mask across every offset of the transfer, so one pass of the sweep hits the collision cycle. Each pass checks that the retired line delivered exactly one byte and that its companion line also ran. Timeout is reached by a memory model that can stop acknowledging. The early stop uses a slow memory, so the rewrite of the count arrives in the middle of a transfer.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam logic [1:0] RA_CSR = 2'd0;
  localparam logic [1:0] RA_CAR = 2'd1;
  localparam logic [1:0] RA_BCR = 2'd2;
  localparam logic [1:0] RA_BAR = 2'd3;

  localparam int CB_DONE  = 15;
  localparam int CB_IEN   = 13;
  localparam int CB_MERR  = 10;
  localparam int CB_MCLR  = 8;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_DLV} fstate_t;

  // next byte pointer: one step, carry runs into extension bits
  function automatic logic [17:0] addr_step(input logic [17:0] a);
    return a + 18'd1;
  endfunction

  // negative count climbs toward zero
  function automatic logic [15:0] cnt_step(input logic [15:0] c);
    return c + 16'd1;
  endfunction
endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
  parameter int NL = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NL-1:0]          req,
  input  logic                   take,
  output logic                   gnt_vld,
  output logic [$clog2(NL)-1:0]  gnt_idx
);
  localparam int LW = $clog2(NL);

  logic [LW-1:0] last;

  // search starts just after the last winner; last itself has lowest priority
  always_comb begin
    logic [LW-1:0] idx;
    gnt_vld = 1'b0;
    gnt_idx = last;
    for (int k = NL; k >= 1; k--) begin
      idx = LW'((int'(last) + k) % NL);
      if (req[idx]) begin
        gnt_vld = 1'b1;
        gnt_idx = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last <= LW'(NL - 1);
    else if (take) last <= gnt_idx;
  end
endmodule

// File: rtl/txdma_fetch.sv
module txdma_fetch
  import txdma_pkg::*;
#(
  parameter int NL  = 16,
  parameter int AW  = 18,
  parameter int TMO = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [$clog2(NL)-1:0] start_line,
  input  logic [AW-1:0]         start_addr,
  output logic                  mem_req,
  output logic [AW-1:0]         mem_addr,
  input  logic                  mem_ack,
  input  logic [7:0]            mem_rdata,
  output logic                  tx_valid,
  output logic [$clog2(NL)-1:0] tx_line,
  output logic [7:0]            tx_data,
  input  logic                  sink_rdy,
  output logic                  busy,
  output logic [$clog2(NL)-1:0] cur_line,
  output logic                  ack_evt,
  output logic                  tmo_evt
);
  localparam int LW = $clog2(NL);
  localparam int TW = $clog2(TMO);

  fstate_t       st;
  logic [LW-1:0] line_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [TW-1:0] tcnt;

  assign mem_req  = (st == FS_REQ);
  assign mem_addr = addr_q;
  assign tx_valid = (st == FS_DLV);
  assign tx_line  = line_q;
  assign tx_data  = data_q;
  assign busy     = (st != FS_IDLE);
  assign cur_line = line_q;
  assign ack_evt  = mem_req && mem_ack;
  assign tmo_evt  = mem_req && !mem_ack && (tcnt == TW'(TMO - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      line_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      tcnt   <= '0;
    end else begin
      unique case (st)
        FS_IDLE: if (start) begin
          st     <= FS_REQ;
          line_q <= start_line;
          addr_q <= start_addr;
          tcnt   <= '0;
        end
        FS_REQ: begin
          if (ack_evt) begin
            st     <= FS_DLV;
            data_q <= mem_rdata;
          end else if (tmo_evt) begin
            st <= FS_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        FS_DLV: if (sink_rdy) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
#(
  parameter int NL  = 16,
  parameter int AW  = 18,
  parameter int TMO = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [1:0]            host_addr,
  input  logic [15:0]           host_wdata,
  output logic [15:0]           host_rdata,
  output logic                  irq,
  output logic                  mem_req,
  output logic [AW-1:0]         mem_addr,
  input  logic                  mem_ack,
  input  logic [7:0]            mem_rdata,
  output logic                  tx_valid,
  output logic [$clog2(NL)-1:0] tx_line,
  output logic [7:0]            tx_data,
  input  logic [NL-1:0]         tx_ready
);
  localparam int LW = $clog2(NL);
  localparam int EW = AW - 16;

  logic [15:0]   car [NL];
  logic [EW-1:0] ext [NL];
  logic [15:0]   cnt [NL];
  logic [NL-1:0] bar;
  logic [LW-1:0] sel;
  logic          ti_q, tie_q, nxm_q;

  logic [NL-1:0] elig, done_vec, tmo_clr;
  logic          gnt_vld, start, busy, ack_evt, tmo_evt;
  logic [LW-1:0] gnt_idx, cur_line;
  logic [AW-1:0] nxt_addr;

  wire wr_csr = host_we && (host_addr == RA_CSR);
  wire wr_car = host_we && (host_addr == RA_CAR);
  wire wr_bcr = host_we && (host_addr == RA_BCR);
  wire wr_bar = host_we && (host_addr == RA_BAR);

  assign nxt_addr = addr_step(mem_addr);
  assign start    = !busy && gnt_vld;

  txdma_rr_arb #(.NL(NL)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .take(start),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  txdma_fetch #(.NL(NL), .AW(AW), .TMO(TMO)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .start_line(gnt_idx),
    .start_addr({ext[gnt_idx], car[gnt_idx]}),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_line(tx_line), .tx_data(tx_data),
    .sink_rdy(tx_ready[tx_line]), .busy(busy), .cur_line(cur_line),
    .ack_evt(ack_evt), .tmo_evt(tmo_evt)
  );

  // banked per-line pointer and count; host access wins over a same-cycle fetch update
  for (genvar i = 0; i < NL; i++) begin : g_line
    wire fetch_me = ack_evt && (cur_line == LW'(i));
    wire own_line = busy && (cur_line == LW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        car[i] <= '0;
        ext[i] <= '0;
        cnt[i] <= '0;
      end else begin
        if (wr_car && sel == LW'(i))                    car[i] <= host_wdata;
        else if (fetch_me)                              car[i] <= nxt_addr[15:0];
        if (wr_csr && host_wdata[LW-1:0] == LW'(i))     ext[i] <= host_wdata[5:4];
        else if (fetch_me)                              ext[i] <= nxt_addr[AW-1:16];
        if (wr_bcr && sel == LW'(i))                    cnt[i] <= host_wdata;
        else if (fetch_me)                              cnt[i] <= cnt_step(cnt[i]);
      end
    end

    assign elig[i]     = bar[i] && (cnt[i] != '0);
    assign done_vec[i] = bar[i] && (cnt[i] == '0) && !own_line;
    assign tmo_clr[i]  = tmo_evt && (cur_line == LW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar   <= '0;
      sel   <= '0;
      ti_q  <= 1'b0;
      tie_q <= 1'b0;
      nxm_q <= 1'b0;
    end else begin
      bar <= (wr_bar ? host_wdata[NL-1:0] : bar) & ~done_vec & ~tmo_clr;
      if (wr_csr) begin
        sel   <= host_wdata[LW-1:0];
        tie_q <= host_wdata[CB_IEN];
      end
      if (|done_vec)                           ti_q <= 1'b1;
      else if (wr_csr && !host_wdata[CB_DONE]) ti_q <= 1'b0;
      if (tmo_evt)                             nxm_q <= 1'b1;
      else if (wr_csr && host_wdata[CB_MCLR])  nxm_q <= 1'b0;
    end
  end

  assign irq = ti_q && tie_q;

  always_comb begin
    unique case (host_addr)
      RA_CSR:  host_rdata = {ti_q, 1'b0, tie_q, 2'b00, nxm_q, 4'b0000,
                             2'(ext[sel]), 4'(sel)};
      RA_CAR:  host_rdata = car[sel];
      RA_BCR:  host_rdata = cnt[sel];
      default: host_rdata = 16'(bar);
    endcase
  end
endmodule

// File: rtl/txdma_seq_chk.sv
module txdma_seq_chk #(
  parameter int NL  = 16,
  parameter int AW  = 18,
  parameter int TMO = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mem_req,
  input logic                  mem_ack,
  input logic [AW-1:0]         mem_addr,
  input logic                  tx_valid,
  input logic                  tx_rdy_sel,
  input logic [7:0]            tx_data,
  input logic [$clog2(NL)-1:0] tx_line,
  input logic [NL-1:0]         done_vec,
  input logic [NL-1:0]         bar,
  input logic                  ti,
  input logic                  nxm,
  input logic                  tmo_evt
);
  logic [$clog2(TMO)+1:0] req_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                  req_age <= '0;
    else if (mem_req && !mem_ack) req_age <= req_age + 1'b1;
    else                          req_age <= '0;
  end

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !tmo_evt |=> mem_req && $stable(mem_addr));

  a_r5_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_rdy_sel |=> tx_valid && $stable(tx_data) && $stable(tx_line));

  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ti);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ((bar & $past(done_vec)) == '0));

  a_r9_timeout_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> nxm && !mem_req);

  a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_age <= ($clog2(TMO)+2)'(TMO));

  a_r7_one_job: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));
endmodule

bind txdma_seq txdma_seq_chk #(.NL(NL), .AW(AW), .TMO(TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_rdy_sel(tx_ready[tx_line]),
  .tx_data(tx_data), .tx_line(tx_line), .done_vec(done_vec), .bar(bar),
  .ti(ti_q), .nxm(nxm_q), .tmo_evt(tmo_evt)
);

// File: tb/tb_txdma_seq.sv
`timescale 1ns/1ps
module tb_txdma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        irq;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic        tx_valid;
  logic [3:0]  tx_line;
  logic [7:0]  tx_data;
  logic [15:0] tx_ready = 16'hFFFF;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit dead = 1'b0;
  int lat = 2;
  logic [17:0] exp_addr [16];
  int got [16];
  int data_bad = 0;
  int seq_log [64];
  int seq_n = 0;
  int req_cycles = 0;

  always #4 clk = ~clk;

  txdma_seq dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_line(tx_line), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return a[7:0] ^ {a[17:16], 6'b0};
  endfunction

  // memory model
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req && !dead) begin
        if (wcnt >= lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem_byte(mem_addr);
        end else wcnt++;
      end else if (!mem_req) wcnt = 0;
    end
  end

  // sink monitor
  initial begin
    for (int i = 0; i < 16; i++) begin exp_addr[i] = '0; got[i] = 0; end
    forever begin
      @(negedge clk); #1;
      if (rst_n && tx_valid && tx_ready[tx_line]) begin
        if (tx_data !== mem_byte(exp_addr[tx_line])) data_bad++;
        exp_addr[tx_line] = exp_addr[tx_line] + 18'd1;
        got[tx_line]++;
        if (seq_n < 64) begin seq_log[seq_n] = int'(tx_line); seq_n++; end
      end
      if (mem_req) req_cycles++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #2 d = host_rdata;
  endtask

  task automatic setup(input int l, input logic [17:0] a, input int n);
    wr(2'd0, 16'h2000 | (16'(a[17:16]) << 4) | 16'(l));
    wr(2'd1, a[15:0]);
    wr(2'd2, 16'(-n));
    exp_addr[l] = a;
    got[l] = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] b;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd3, b);
      if (b == 16'h0) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk(v == 16'h0, "R1 csr after reset", v, 0);
    rd(2'd3, v); chk(v == 16'h0, "R1 mask after reset", v, 0);
    chk(!irq && !mem_req, "R1 irq/mem_req low", {irq, mem_req}, 0);
  endtask

  task automatic t_select();
    logic [15:0] v;
    setup(2, 18'h1_1234, 3);
    setup(5, 18'h3_BEEF, 7);
    rd(2'd1, v); chk(v == 16'hBEEF, "R2 line5 addr", v, 16'hBEEF);
    rd(2'd0, v); chk(v[5:4] == 2'd3, "R3 line5 ext", v[5:4], 3);
    rd(2'd2, v); chk(v == 16'hFFF9, "R2 line5 count", v, 16'hFFF9);
    wr(2'd0, 16'h2012);
    rd(2'd1, v); chk(v == 16'h1234, "R2 line2 addr kept", v, 16'h1234);
    rd(2'd2, v); chk(v == 16'hFFFD, "R2 line2 count kept", v, 16'hFFFD);
  endtask

  task automatic t_single();
    logic [15:0] v;
    tx_ready[3] = 1'b0;
    setup(3, 18'h0_0100, 5);
    wr(2'd3, 16'h0008);
    repeat (20) @(negedge clk);
    chk(got[3] == 0 && tx_valid && tx_line == 4'd3, "R5 byte held while not ready", got[3], 0);
    tx_ready[3] = 1'b1;
    wait_idle();
    chk(got[3] == 5, "R5 bytes delivered", got[3], 5);
    chk(data_bad == 0, "R5 byte order/data", data_bad, 0);
    rd(2'd1, v); chk(v == 16'h0105, "R4 address advanced", v, 16'h0105);
    rd(2'd2, v); chk(v == 16'h0000, "R4 count at zero", v, 0);
    rd(2'd0, v); chk(v[15] == 1'b1, "R6 done flag", v[15], 1);
    chk(irq == 1'b1, "R6 irq with enable", irq, 1);
    wr(2'd0, 16'h2003);
    rd(2'd0, v); chk(v[15] == 1'b0 && !irq, "R6 done flag cleared", v[15], 0);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    setup(0, 18'h1_FFFF, 2);
    wr(2'd3, 16'h0001);
    wait_idle();
    rd(2'd1, v); chk(v == 16'h0001, "R4 low address after carry", v, 1);
    rd(2'd0, v); chk(v[5:4] == 2'd2, "R4 carry into ext bits", v[5:4], 2);
    chk(data_bad == 0 && got[0] == 2, "R4 bytes across carry", got[0], 2);
  endtask

  task automatic t_rr();
    bit alt = 1'b1;
    setup(1, 18'h0_0500, 4);
    setup(9, 18'h0_0600, 4);
    seq_n = 0;
    wr(2'd3, 16'h0202);
    wait_idle();
    for (int k = 1; k < 8; k++) if (seq_log[k] == seq_log[k-1]) alt = 1'b0;
    chk(got[1] == 4 && got[9] == 4, "R7 both lines finished", got[1] + got[9], 8);
    chk(alt, "R7 round-robin alternation", alt, 1);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    lat = 6;
    setup(4, 18'h0_0400, 200);
    wr(2'd3, 16'h0010);
    repeat (30) @(negedge clk);
    wr(2'd2, 16'hFFFF);
    wait_idle();
    lat = 2;
    chk(got[4] > 0 && got[4] < 200, "R8 stopped early", got[4], 199);
    rd(2'd1, v); chk(v == 16'(16'h0400 + got[4]), "R8 address shows progress", v, 16'h0400 + got[4]);
    rd(2'd2, v); chk(v == 16'h0000, "R8 count zero after stop", v, 0);
  endtask

  task automatic t_nxm();
    logic [15:0] v;
    dead = 1'b1;
    setup(6, 18'h0_0700, 3);
    req_cycles = 0;
    wr(2'd3, 16'h0040);
    repeat (45) @(negedge clk);
    rd(2'd0, v);
    chk(v[10] == 1'b1, "R9 memory error flag", v[10], 1);
    chk(v[15] == 1'b0, "R9 no done flag on timeout", v[15], 0);
    rd(2'd3, v); chk(v == 16'h0000, "R9 line retired", v, 0);
    chk(req_cycles == 32, "R9 request window length", req_cycles, 32);
    rd(2'd1, v); chk(v == 16'h0700 && got[6] == 0, "R9 no byte taken", v, 16'h0700);
    dead = 1'b0;
    wr(2'd0, 16'h2106);
    rd(2'd0, v); chk(v[10] == 1'b0, "R9 error flag cleared", v[10], 0);
  endtask

  task automatic t_zero();
    logic [15:0] v;
    setup(7, 18'h0_0800, 0);
    req_cycles = 0;
    wr(2'd3, 16'h0080);
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk(v == 16'h0000, "R11 zero-count line retired", v, 0);
    rd(2'd0, v); chk(v[15] == 1'b1, "R11 done flag", v[15], 1);
    chk(got[7] == 0 && req_cycles == 0, "R11 no fetch", got[7], 0);
  endtask

  task automatic t_race();
    int bad = 0;
    logic [15:0] v;
    for (int d = 0; d < 14; d++) begin
      setup(10, 18'h0_0A00, 1);
      setup(11, 18'h0_0B00, 1);
      wr(2'd3, 16'h0400);
      repeat (d) @(negedge clk);
      wr(2'd3, 16'h0C00);
      wait_idle();
      if (got[10] != 1 || got[11] != 1) bad++;
    end
    rd(2'd3, v);
    chk(bad == 0, "R10 clear wins over concurrent mask write", bad, 0);
    chk(v == 16'h0000 && data_bad == 0, "R10 mask idle after sweep", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_single();
    t_carry();
    t_rr();
    t_stop();
    t_nxm();
    t_zero();
    t_race();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule